// File: doc/BRIEF.md
# Serial Wire Debug Host Transfer Engine

This block is the host end of a two-wire debug link. It generates the serial debug clock and drives, releases and samples a single bidirectional data line to carry out exactly one transfer per request. A request names the port (debug port or access port), the direction, a two-bit register address and, for writes, a 32-bit word. The engine then runs the whole packet. It sends the eight-bit request header and hands the line to the target. It collects the three-bit acknowledge. If the target answers OK, it moves 32 data bits plus an even parity bit in the direction the header named.

On completion the engine pulses a done strobe for one cycle and presents the acknowledge code, the read word and two flags: one for a read parity mismatch and one for an acknowledge code outside the defined set. Each serial bit is built from a programmable number of system clocks, so the link speed can be lowered for slow or low-voltage targets. The line is changed a programmable number of system clocks ahead of each rising serial clock edge, which leaves settling time on long cables. Between transfers the serial clock is stopped low. Retrying, abort sequencing and register-level programming sequences belong to the requester.

Top module: `swd_xfer_engine`

## Requirements
- R1: The header is sent as eight host-driven bits in this order: start (1), port select (1 = access port), direction (1 = read), address bit 0, address bit 1, even parity over the four preceding field bits, stop (0), park (1). A debug-port read of address 0 therefore sends 1,0,1,0,0,1,0,1.
- R2: After the header the host releases the line (output enable low) for one turnaround bit and keeps it released through the three acknowledge bits. The acknowledge is assembled least significant bit first: OK = 3'b001, WAIT = 3'b010, FAULT = 3'b100. `rsp_ack` reports the code, and host and target never drive the line in the same cycle.
- R3: On OK for a write, one more released turnaround bit follows. The host then drives the 32 write bits, least significant first, followed by their even parity bit.
- R4: On OK for a read, the 33 target bits (data least significant first, then parity) follow the acknowledge with no turnaround, and one released turnaround bit ends the packet. `rsp_rdata` then holds the word.
- R5: `rsp_parity_err` is 1 after an OK read whose 33 received bits have odd parity, and 0 after every other transfer.
- R6: Any acknowledge other than OK ends the transfer after one released turnaround bit, with no data phase. `rsp_rdata` then reads 0. `rsp_proto_err` is 1 exactly when the code is not one of OK, WAIT or FAULT.
- R7: Within a bit the host changes `swdio_o`/`swdio_oe` exactly S system clocks before the rising `swclk` edge, where S is the effective set-up count. It never changes them on the rising edge itself or while `swclk` is high.
- R8: During a transfer `swclk` has a period of 2·H system clocks, with H clocks low followed by H clocks high, where H is the effective half-period. Between transfers `swclk` stays low.
- R9: The effective values are clamped. H is 2 when `cfg_half` < 2, else `cfg_half`. S is 1 when `cfg_setup` = 0, H−1 when `cfg_setup` > H−1, else `cfg_setup`.
- R10: `cfg_half` and `cfg_setup` are captured when a request is accepted. Changes during a transfer have no effect on it.
- R11: `req_start` is accepted only while no transfer is in progress, and a pulse during a transfer is ignored. `rsp_done` is a single-cycle pulse in the first idle cycle, and a `req_start` in that same cycle is accepted.
- R12: After reset `swclk` = 0, `swdio_oe` = 1, `swdio_o` = 0, `rsp_done` = 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Single-cycle request strobe |
| req_apndp | input | 1 | 1 selects the access port, 0 the debug port |
| req_rnw | input | 1 | 1 read, 0 write |
| req_addr | input | 2 | Register address bits 3:2 (bit 0 sent first) |
| req_wdata | input | 32 | Write word |
| cfg_half | input | DIV_W | System clocks per serial clock half-period |
| cfg_setup | input | DIV_W | System clocks between a line change and the rising serial clock |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_ack | output | 3 | Acknowledge code received |
| rsp_proto_err | output | 1 | Acknowledge code outside the defined set |
| rsp_parity_err | output | 1 | Read parity mismatch |
| rsp_rdata | output | 32 | Read word |
| swclk | output | 1 | Serial debug clock |
| swdio_o | output | 1 | Data line value when driving |
| swdio_oe | output | 1 | Data line output enable |
| swdio_i | input | 1 | Data line as seen at the pin |

## Verification
The completion of one transfer and the acceptance of the next can fall in the same cycle. The done strobe goes out in the first idle cycle, and a start presented then must launch a fresh packet. The bench provokes this by raising the next request as soon as its monitor sees the done strobe. It then judges the second packet's header, data and timing against the scoreboard and confirms that the first result was reported exactly once. A start pulse and a configuration change issued in the middle of a transfer are also aimed at the same cycles as live bit strobes. These are judged by the absence of any extra done, the unchanged header and the unchanged clock period.

// File: rtl/swd_xfer_pkg.sv
// Shared constants, state type and header builder for the serial debug
// host transfer engine. Assumes a 32-bit data word and a 3-bit acknowledge.
package swd_xfer_pkg;

    localparam int WORD_W    = 32;
    localparam int HDR_BITS  = 8;
    localparam int ACK_BITS  = 3;
    localparam int DATA_BITS = WORD_W + 1;
    localparam int CNT_W     = 6;

    localparam logic [ACK_BITS-1:0] ACK_OK    = 3'b001;
    localparam logic [ACK_BITS-1:0] ACK_WAIT  = 3'b010;
    localparam logic [ACK_BITS-1:0] ACK_FAULT = 3'b100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_TRN1,
        ST_ACK,
        ST_TRN2,
        ST_WDATA,
        ST_RDATA,
        ST_TRN3
    } seq_state_t;

    // Build the header with bit 0 = first bit on the wire.
    function automatic logic [HDR_BITS-1:0] build_header(
        input logic       apndp,
        input logic       rnw,
        input logic [1:0] addr
    );
        logic par;
        par = apndp ^ rnw ^ addr[0] ^ addr[1];
        return {1'b1, 1'b0, par, addr[1], addr[0], rnw, apndp, 1'b1};
    endfunction

endpackage

// File: rtl/swd_bit_timer.sv
// Serial bit timer. Each bit is a low phase of `half` clocks followed by a
// high phase of `half` clocks. It produces a launch strobe `setup` clocks
// before the rising edge, a sample strobe in the last low cycle and a
// bit-end strobe in the last high cycle.
// Assumes half >= 2 and 1 <= setup <= half-1 (clamped by the caller).
module swd_bit_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    input  logic [DIV_W-1:0] setup,
    output logic             swclk,
    output logic             launch,
    output logic             sample,
    output logic             bit_end
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;
    logic             hi;
    logic             last;

    assign last = (cnt == half - ONE);

    // Phase counter: advances while running, parks at the start of a low phase otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            hi  <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            hi  <= 1'b0;
        end else if (last) begin
            cnt <= '0;
            hi  <= ~hi;
        end else begin
            cnt <= cnt + ONE;
        end
    end

    // Strobe decode for the current phase position.
    always_comb begin
        launch  = run && !hi && (cnt == half - ONE - setup);
        sample  = run && !hi && last;
        bit_end = run &&  hi && last;
    end

    assign swclk = hi;

endmodule

// File: rtl/swd_sequencer.sv
// Packet sequencer. Walks the header, turnaround, acknowledge and data
// phases one bit at a time on the timer strobes, drives or releases the
// line, collects the acknowledge and read bits and reports the result.
// Assumes launch, sample and bit_end never coincide.
module swd_sequencer
    import swd_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              apndp,
    input  logic              rnw,
    input  logic [1:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              launch,
    input  logic              sample,
    input  logic              bit_end,
    input  logic              swdio_i,
    output logic              run,
    output logic              swdio_o,
    output logic              swdio_oe,
    output logic              done,
    output logic [ACK_BITS-1:0] ack,
    output logic              proto_err,
    output logic              parity_err,
    output logic [WORD_W-1:0] rdata
);

    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] ACK_LAST  = CNT_W'(ACK_BITS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_BITS - 1);

    seq_state_t             state;
    logic [CNT_W-1:0]       bitcnt;
    logic [DATA_BITS-1:0]   tx;
    logic [DATA_BITS-1:0]   rx;
    logic [ACK_BITS-1:0]    ack_sr;
    logic [WORD_W-1:0]      wdata_q;
    logic                   rnw_q;
    logic                   ack_ok;
    logic                   drive_bit;
    logic                   finish;

    // Phase decode shared by the sequencing process.
    always_comb begin
        ack_ok    = (ack_sr == ACK_OK);
        drive_bit = (state == ST_HDR) || (state == ST_WDATA);
        finish    = bit_end && (
                        ((state == ST_TRN2) && !(ack_ok && !rnw_q)) ||
                        ((state == ST_WDATA) && (bitcnt == DATA_LAST)) ||
                        (state == ST_TRN3));
    end

    // Packet state, line drive, receive shifting and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            tx         <= '0;
            rx         <= '0;
            ack_sr     <= '0;
            wdata_q    <= '0;
            rnw_q      <= 1'b0;
            swdio_o    <= 1'b0;
            swdio_oe   <= 1'b1;
            done       <= 1'b0;
            ack        <= '0;
            proto_err  <= 1'b0;
            parity_err <= 1'b0;
            rdata      <= '0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE) begin
                if (start) begin
                    tx      <= {{(DATA_BITS-HDR_BITS){1'b0}}, build_header(apndp, rnw, addr)};
                    wdata_q <= wdata;
                    rnw_q   <= rnw;
                    bitcnt  <= '0;
                    state   <= ST_HDR;
                end
            end else begin
                if (launch) begin
                    if (drive_bit) begin
                        swdio_o  <= tx[0];
                        swdio_oe <= 1'b1;
                        tx       <= tx >> 1;
                    end else begin
                        swdio_oe <= 1'b0;
                    end
                end
                if (sample && (state == ST_ACK)) begin
                    ack_sr <= {swdio_i, ack_sr[ACK_BITS-1:1]};
                end
                if (sample && (state == ST_RDATA)) begin
                    rx <= {swdio_i, rx[DATA_BITS-1:1]};
                end
                if (bit_end) begin
                    bitcnt <= bitcnt + CNT_W'(1);
                    case (state)
                        ST_HDR: if (bitcnt == HDR_LAST) begin
                            bitcnt <= '0;
                            state  <= ST_TRN1;
                        end
                        ST_TRN1: begin
                            bitcnt <= '0;
                            state  <= ST_ACK;
                        end
                        ST_ACK: if (bitcnt == ACK_LAST) begin
                            bitcnt <= '0;
                            tx     <= {^wdata_q, wdata_q};
                            state  <= (ack_ok && rnw_q) ? ST_RDATA : ST_TRN2;
                        end
                        ST_TRN2: begin
                            bitcnt <= '0;
                            if (ack_ok && !rnw_q) state <= ST_WDATA;
                        end
                        ST_RDATA: if (bitcnt == DATA_LAST) begin
                            bitcnt <= '0;
                            state  <= ST_TRN3;
                        end
                        default: ;
                    endcase
                end
                if (finish) begin
                    state      <= ST_IDLE;
                    done       <= 1'b1;
                    swdio_o    <= 1'b0;
                    swdio_oe   <= 1'b1;
                    ack        <= ack_sr;
                    proto_err  <= !((ack_sr == ACK_OK) || (ack_sr == ACK_WAIT) ||
                                    (ack_sr == ACK_FAULT));
                    parity_err <= ack_ok && rnw_q && (^rx);
                    rdata      <= (ack_ok && rnw_q) ? rx[WORD_W-1:0] : '0;
                end
            end
        end
    end

    assign run = (state != ST_IDLE);

endmodule

// File: rtl/swd_xfer_engine.sv
// Top of the serial debug host transfer engine. Clamps and captures the
// timing configuration at request acceptance, then couples the bit timer
// to the packet sequencer. Assumes DIV_W >= 2.
module swd_xfer_engine
    import swd_xfer_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              req_apndp,
    input  logic              req_rnw,
    input  logic [1:0]        req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [DIV_W-1:0]  cfg_half,
    input  logic [DIV_W-1:0]  cfg_setup,
    output logic              rsp_done,
    output logic [2:0]        rsp_ack,
    output logic              rsp_proto_err,
    output logic              rsp_parity_err,
    output logic [31:0]       rsp_rdata,
    output logic              swclk,
    output logic              swdio_o,
    output logic              swdio_oe,
    input  logic              swdio_i
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
    localparam logic [DIV_W-1:0] TWO = DIV_W'(2);

    logic [DIV_W-1:0] half_eff;
    logic [DIV_W-1:0] setup_eff;
    logic [DIV_W-1:0] half_q;
    logic [DIV_W-1:0] setup_q;
    logic             seq_run;
    logic             t_launch;
    logic             t_sample;
    logic             t_bit_end;

    // Clamp the requested timing into the range the bit timer supports.
    always_comb begin
        half_eff = (cfg_half < TWO) ? TWO : cfg_half;
        if (cfg_setup == '0)
            setup_eff = ONE;
        else if (cfg_setup > half_eff - ONE)
            setup_eff = half_eff - ONE;
        else
            setup_eff = cfg_setup;
    end

    // Capture the timing for the whole transfer when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q  <= TWO;
            setup_q <= ONE;
        end else if (req_start && !seq_run) begin
            half_q  <= half_eff;
            setup_q <= setup_eff;
        end
    end

    swd_bit_timer #(.DIV_W(DIV_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (seq_run),
        .half    (half_q),
        .setup   (setup_q),
        .swclk   (swclk),
        .launch  (t_launch),
        .sample  (t_sample),
        .bit_end (t_bit_end)
    );

    swd_sequencer seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (req_start),
        .apndp      (req_apndp),
        .rnw        (req_rnw),
        .addr       (req_addr),
        .wdata      (req_wdata),
        .launch     (t_launch),
        .sample     (t_sample),
        .bit_end    (t_bit_end),
        .swdio_i    (swdio_i),
        .run        (seq_run),
        .swdio_o    (swdio_o),
        .swdio_oe   (swdio_oe),
        .done       (rsp_done),
        .ack        (rsp_ack),
        .proto_err  (rsp_proto_err),
        .parity_err (rsp_parity_err),
        .rdata      (rsp_rdata)
    );

endmodule

// File: rtl/swd_xfer_engine_chk.sv
// Property checker for the transfer engine, attached by bind. Tracks the
// clocks since the last line change with a saturating counter, so the
// set-up window needs no deep history.
module swd_xfer_engine_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             swclk,
    input logic             swdio_o,
    input logic             swdio_oe,
    input logic             run,
    input logic [DIV_W-1:0] setup_q,
    input logic             rsp_done,
    input logic [2:0]       rsp_ack,
    input logic             rsp_proto_err,
    input logic             rsp_parity_err
);

    logic [1:0]     line_prev;
    logic           sw_prev;
    logic [DIV_W:0] gap;
    logic           chg;

    assign chg = ({swdio_oe, swdio_o} != line_prev);

    // History of the line and clock, plus clocks since the last line change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_prev <= 2'b10;
            sw_prev   <= 1'b0;
            gap       <= '1;
        end else begin
            line_prev <= {swdio_oe, swdio_o};
            sw_prev   <= swclk;
            if (chg)
                gap <= (DIV_W+1)'(1);
            else if (gap != '1)
                gap <= gap + (DIV_W+1)'(1);
        end
    end

    // R7: the line settles at least the set-up count before each rising edge.
    a_r7_setup_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (swclk && !sw_prev) |-> (!chg && (gap >= {1'b0, setup_q})));

    // R7: no line change while the serial clock stays high.
    a_r7_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (swclk && sw_prev) |-> !chg);

    // R8: the serial clock is parked low between transfers.
    a_r8_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !swclk);

    // R11: done is a single-cycle pulse.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R5: a parity error is only reported alongside an OK acknowledge.
    a_r5_parity_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_parity_err |-> (rsp_ack == 3'b001));

    // R6: protocol error flags exactly the undefined codes.
    a_r6_proto_code: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (rsp_proto_err == !((rsp_ack == 3'b001) || (rsp_ack == 3'b010) ||
                                         (rsp_ack == 3'b100))));

endmodule

bind swd_xfer_engine swd_xfer_engine_chk #(.DIV_W(DIV_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .swclk          (swclk),
    .swdio_o        (swdio_o),
    .swdio_oe       (swdio_oe),
    .run            (seq_run),
    .setup_q        (setup_q),
    .rsp_done       (rsp_done),
    .rsp_ack        (rsp_ack),
    .rsp_proto_err  (rsp_proto_err),
    .rsp_parity_err (rsp_parity_err)
);

// File: tb/swd_xfer_engine_tb_top.sv
// Scoreboard bench: the driver task pushes the expected outcome of each
// request, a scripted target answers on the wire, and the monitor pops and
// compares at every done strobe.
module swd_xfer_engine_tb_top;

    localparam int DIV_W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             req_start = 1'b0, req_apndp = 1'b0, req_rnw = 1'b0;
    logic [1:0]       req_addr = '0;
    logic [31:0]      req_wdata = '0;
    logic [DIV_W-1:0] cfg_half = 8'd2, cfg_setup = 8'd1;
    logic             rsp_done, rsp_proto_err, rsp_parity_err;
    logic [2:0]       rsp_ack;
    logic [31:0]      rsp_rdata;
    logic             swclk, swdio_o, swdio_oe;
    logic             tgt_oe = 1'b0, tgt_o = 1'b0;
    wire              line = swdio_oe ? swdio_o : (tgt_oe ? tgt_o : 1'b1);

    swd_xfer_engine #(.DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_apndp(req_apndp),
        .req_rnw(req_rnw), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_half(cfg_half), .cfg_setup(cfg_setup), .rsp_done(rsp_done),
        .rsp_ack(rsp_ack), .rsp_proto_err(rsp_proto_err),
        .rsp_parity_err(rsp_parity_err), .rsp_rdata(rsp_rdata), .swclk(swclk),
        .swdio_o(swdio_o), .swdio_oe(swdio_oe), .swdio_i(line)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    // Scripted target: samples host bits and drives its own on rising swclk.
    int          ec = 0;
    logic [2:0]  t_ack = 3'b001;
    logic [31:0] t_data = '0;
    bit          t_rnw = 1'b0, t_flip = 1'b0;
    logic [7:0]  cap_hdr = '0;
    logic [32:0] cap_w = '0;

    always @(posedge swclk) begin
        if (ec < 8) cap_hdr[ec] = line;
        if (!t_rnw && t_ack == 3'b001 && ec >= 13 && ec <= 45) cap_w[ec-13] = line;
        if (ec >= 8 && ec <= 10) begin
            tgt_oe = 1'b1;
            tgt_o  = t_ack[ec-8];
        end else if (t_rnw && t_ack == 3'b001 && ec >= 11 && ec <= 43) begin
            tgt_oe = 1'b1;
            tgt_o  = (ec == 43) ? ((^t_data) ^ t_flip) : t_data[ec-11];
        end else begin
            tgt_oe = 1'b0;
        end
        ec++;
    end

    // Timing observer (R7, R8, R2 conflicts, R11 spurious activity).
    int   exp_half = 2, exp_setup = 1;
    bit   busy_tb = 1'b0;
    bit   tm_first = 1'b1, tm_bad_setup = 1'b0, tm_bad_period = 1'b0, conflict = 1'b0;
    bit   spurious = 1'b0;
    logic [1:0] pl = 2'b10;
    int   gap = 0, since_rise = 0;
    bit   psw = 1'b0;

    always @(negedge clk) begin
        if ({swdio_oe, swdio_o} != pl) gap = 0; else gap++;
        pl = {swdio_oe, swdio_o};
        since_rise++;
        if (rst_n && swclk && !psw) begin
            if (gap < 2 * exp_half && gap != exp_setup) tm_bad_setup = 1'b1;
            if (!tm_first && since_rise != 2 * exp_half) tm_bad_period = 1'b1;
            tm_first   = 1'b0;
            since_rise = 0;
            if (!busy_tb) spurious = 1'b1;
        end
        if (swclk && psw && gap == 0) tm_bad_setup = 1'b1;
        psw = swclk;
        if (swdio_oe && tgt_oe) conflict = 1'b1;
    end

    typedef struct {
        logic [2:0]  ack;
        bit          proto;
        bit          perr;
        logic [31:0] rdata;
        logic [7:0]  hdr;
        bit          wr_chk;
        logic [32:0] wbits;
        string       tag;
    } exp_t;

    exp_t sb[$];

    // Monitor: compares each completed transfer against the queue head.
    bit prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n && rsp_done) begin
            check(!prev_done, "R11 done lasted more than one cycle", 1, 0);
            if (sb.size() == 0) begin
                check(1'b0, "R11 done with no accepted request", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_ack == e.ack, {e.tag, " R2 acknowledge"}, rsp_ack, e.ack);
                check(rsp_proto_err == e.proto, {e.tag, " R6 protocol error flag"},
                      rsp_proto_err, e.proto);
                check(rsp_parity_err == e.perr, {e.tag, " R5 parity error flag"},
                      rsp_parity_err, e.perr);
                check(rsp_rdata == e.rdata, {e.tag, " R4/R6 read word"}, rsp_rdata, e.rdata);
                check(cap_hdr == e.hdr, {e.tag, " R1 header bits"}, cap_hdr, e.hdr);
                if (e.wr_chk)
                    check(cap_w == e.wbits, {e.tag, " R3 write bits"}, cap_w, e.wbits);
                check(!tm_bad_setup, {e.tag, " R7 set-up before rising edge"}, 1, 0);
                check(!tm_bad_period, {e.tag, " R8 serial clock period"}, 1, 0);
                check(!conflict, {e.tag, " R2 both ends driving"}, 1, 0);
            end
            busy_tb = 1'b0;
        end
        prev_done = rsp_done;
    end

    // Driver: waits its turn, scripts the target, pushes the expectation, pulses start.
    task automatic run_xfer(input bit apndp, input bit rnw, input logic [1:0] addr,
                            input logic [31:0] wd, input logic [2:0] ack,
                            input logic [31:0] rd, input bit flip, input int half,
                            input int setup, input bit b2b, input string tag);
        exp_t e;
        int eh, es;
        bit ok;
        eh = (half < 2) ? 2 : half;
        es = (setup == 0) ? 1 : ((setup > eh - 1) ? eh - 1 : setup);
        ok = (ack == 3'b001);
        e.ack    = ack;
        e.proto  = !(ack == 3'b001 || ack == 3'b010 || ack == 3'b100);
        e.perr   = ok && rnw && flip;
        e.rdata  = (ok && rnw) ? rd : 32'h0;
        e.hdr    = {1'b1, 1'b0, apndp ^ rnw ^ addr[0] ^ addr[1], addr[1], addr[0], rnw, apndp, 1'b1};
        e.wr_chk = ok && !rnw;
        e.wbits  = {^wd, wd};
        e.tag    = tag;
        if (b2b) begin
            do @(negedge clk); while (!rsp_done);
        end else begin
            while (busy_tb) @(negedge clk);
            @(negedge clk);
        end
        #1;
        t_ack = ack; t_data = rd; t_rnw = rnw; t_flip = flip; ec = 0;
        exp_half = eh; exp_setup = es;
        tm_first = 1'b1; tm_bad_setup = 1'b0; tm_bad_period = 1'b0; conflict = 1'b0;
        sb.push_back(e);
        busy_tb   = 1'b1;
        req_apndp = apndp; req_rnw = rnw; req_addr = addr; req_wdata = wd;
        cfg_half  = DIV_W'(half); cfg_setup = DIV_W'(setup);
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(swclk == 1'b0, "R12 swclk after reset", swclk, 0);
        check(swdio_oe == 1'b1, "R12 output enable after reset", swdio_oe, 1);
        check(swdio_o == 1'b0, "R12 line value after reset", swdio_o, 0);
        check(rsp_done == 1'b0, "R12 done after reset", rsp_done, 0);
        check({rsp_ack, rsp_proto_err, rsp_parity_err, rsp_rdata} == '0,
              "R12 results after reset", {rsp_ack, rsp_rdata}, 0);

        // R1/R4: identification read of debug-port address 0 (header 1,0,1,0,0,1,0,1).
        run_xfer(0, 1, 2'b00, 32'h0, 3'b001, 32'h2BA01477, 0, 4, 2, 0, "idcode read");
        // R3: access-port write.
        run_xfer(1, 0, 2'b01, 32'hDEADBEEF, 3'b001, 32'h0, 0, 3, 1, 0, "ap write");
        // R6: WAIT on a read, FAULT on a write.
        run_xfer(1, 1, 2'b11, 32'h0, 3'b010, 32'h55AA55AA, 0, 2, 1, 0, "wait read");
        run_xfer(0, 0, 2'b10, 32'h13579BDF, 3'b100, 32'h0, 0, 5, 3, 0, "fault write");
        // R5: corrupted read parity.
        run_xfer(1, 1, 2'b11, 32'h0, 3'b001, 32'h80000001, 1, 3, 2, 0, "bad parity");
        // R6: undefined acknowledge code.
        run_xfer(0, 1, 2'b01, 32'h0, 3'b111, 32'h0, 0, 2, 1, 0, "undefined ack");
        // R9: half below minimum and zero set-up, then set-up beyond half.
        run_xfer(1, 0, 2'b00, 32'h12345678, 3'b001, 32'h0, 0, 1, 0, 0, "R9 clamp low");
        run_xfer(0, 1, 2'b11, 32'h0, 3'b001, 32'hFFFFFFFF, 0, 5, 9, 0, "R9 clamp setup");
        // R11: next start in the same cycle as done.
        run_xfer(0, 1, 2'b11, 32'h0, 3'b001, 32'h00000000, 0, 3, 1, 0, "R11 first");
        run_xfer(1, 0, 2'b10, 32'hA5A55A5A, 3'b001, 32'h0, 0, 4, 3, 1, "R11 back-to-back");
        // R10/R11: configuration change and start pulse during a transfer are ignored.
        run_xfer(1, 0, 2'b01, 32'h0F0F0F0F, 3'b001, 32'h0, 0, 4, 2, 0, "R10 mid-change");
        repeat (40) @(negedge clk);
        cfg_half = 8'd7; cfg_setup = 8'd1;
        req_apndp = 1'b0; req_rnw = 1'b1; req_addr = 2'b00;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        while (busy_tb) @(negedge clk);
        repeat (300) @(negedge clk);
        check(!spurious, "R11 serial clock ran with no accepted request", spurious, 0);
        check(sb.size() == 0, "R11 requests left without done", sb.size(), 0);
        check(swclk == 1'b0 && swdio_oe == 1'b1, "R8 idle line state",
              {swclk, swdio_oe}, 2'b01);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule